// File: doc/BRIEF.md
# Repeated String Transfer Engine

This block carries out a repeated operation on a sequence of memory elements, in the manner of a repeat-prefixed string instruction. A single start command sets a source pointer, a destination pointer, an element count, an element size, a stepping direction, an operation kind and an accumulator value. The engine then works through the elements one at a time over a simple request/acknowledge memory port. The operation kinds are block move, store-fill from the accumulator, load into the accumulator, scan against the accumulator, and compare of two memory regions.

The count falls by one for each element. The run ends when the count reaches zero. Scan and compare runs also end early once the result of the latest comparison meets the chosen stop condition. After each element, every pointer that the operation uses moves by the element size, upward or downward. When the run ends, the final pointers, the count, the accumulator and the zero flag stay on the result outputs. A host can then continue an interrupted scan or compare from the point where it stopped.

Top module: `rep_string_engine`

## Requirements
- R1: While reset is applied and after reset is released, `busy`, `done` and `mem_req` are all low.
- R2: A start with `cfg_cnt` equal to 0 makes no memory request. `done` is high one cycle after the start, and the result pointers, the count and the accumulator equal the configured values.
- R3: Size code 0 selects 1-byte elements, code 1 selects 2-byte elements, and codes 2 and 3 select 4-byte elements. Each pointer that an element uses moves by exactly the element size.
- R4: With `cfg_dir` at 0, pointers move to higher addresses. With `cfg_dir` at 1, they move to lower addresses.
- R5: Kind 0 (move) reads each element at the source pointer and then writes it to the destination pointer. Both pointers step, the count falls by one per element, and the run ends when the count is 0.
- R6: Kind 1 (store) writes the low element-size bytes of the accumulator to the destination pointer. Only the destination pointer steps.
- R7: Kind 2 (load) replaces the low element-size bytes of the accumulator with the element at the source pointer and keeps the upper bytes. Only the source pointer steps.
- R8: Kind 3 (scan) compares the low element-size bytes of the accumulator with the element at the destination pointer. It sets the zero flag to the equality result, and only the destination pointer steps.
- R9: Kind 4 (compare) reads the element at the source pointer and then the element at the destination pointer. It sets the zero flag to their equality, and both pointers step.
- R10: In scan and compare runs, the run stops after the element whose zero flag equals `cfg_stop_eq`. The pointers and the count have already been updated for that element. Other kinds leave the zero flag at 0.
- R11: A memory request keeps its address, direction and write data unchanged until it is acknowledged.
- R12: A start that arrives while `busy` is high is ignored, and the running operation completes as configured.
- R13: `done` rises when a run completes and stays high until the next accepted start. `done` and `busy` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only while idle |
| cfg_op | input | 3 | Kind: 0 move, 1 store, 2 load, 3 scan, 4 compare (5-7 act as move) |
| cfg_size | input | 2 | Element size code |
| cfg_dir | input | 1 | 0 ascending, 1 descending |
| cfg_stop_eq | input | 1 | Zero-flag value that stops a scan or compare |
| cfg_src | input | AW | Initial source pointer |
| cfg_dst | input | AW | Initial destination pointer |
| cfg_cnt | input | CW | Element count |
| cfg_acc | input | 32 | Initial accumulator |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address of the element |
| mem_size | output | 2 | Element size code of the access |
| mem_wdata | output | 32 | Write data, little-endian, upper bytes zero |
| mem_ack | input | 1 | Acknowledge, and read data valid |
| mem_rdata | input | 32 | Read data, little-endian |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run complete |
| res_src | output | AW | Current or final source pointer |
| res_dst | output | AW | Current or final destination pointer |
| res_cnt | output | CW | Current or final count |
| res_acc | output | 32 | Accumulator |
| res_zf | output | 1 | Zero flag of the latest comparison |

## Verification
The assertions take for granted that the memory side raises `mem_ack` only while `mem_req` is high and holds it for one cycle per access, and that `rst_n` is low before the first edge. The bench's responder follows this rule: it acknowledges after a random delay and always drops the acknowledge in the cycle after. The random configurations keep pointers and element runs inside a 256-byte window with no wrap-around. Memory bytes are drawn from a small set of values, so scan and compare matches occur often.

// File: rtl/rse_pkg.sv
package rse_pkg;

  typedef enum logic [2:0] {
    OP_MOVE  = 3'd0,
    OP_STORE = 3'd1,
    OP_LOAD  = 3'd2,
    OP_SCAN  = 3'd3,
    OP_CMP   = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDA,
    ST_RDB,
    ST_WR,
    ST_STEP
  } st_e;

  localparam int unsigned DATA_W = 32;

  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = 32'h0000_00FF;
      2'd1:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  function automatic st_e first_state(input op_e op);
    case (op)
      OP_SCAN:  first_state = ST_RDB;
      OP_STORE: first_state = ST_WR;
      default:  first_state = ST_RDA;
    endcase
  endfunction

endpackage

// File: rtl/rse_stepper.sv
module rse_stepper
  import rse_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic [1:0]    sz,
  input  logic          dir,
  output logic [AW-1:0] ptr_next
);
  logic [AW-1:0] step;

  assign step = AW'(size_bytes(sz));

  // descending runs subtract, ascending runs add
  always_comb begin
    if (dir) ptr_next = ptr - step;
    else     ptr_next = ptr + step;
  end
endmodule

// File: rtl/rse_match.sv
module rse_match
  import rse_pkg::*;
(
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  input  logic [1:0]        sz,
  output logic              equal
);
  logic [DATA_W-1:0] diff;

  assign diff  = (lhs ^ rhs) & size_mask(sz);
  assign equal = (diff == '0);
endmodule

// File: rtl/rse_seq.sv
module rse_seq
  import rse_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        cfg_op,
  input  logic [1:0]        cfg_size,
  input  logic              cfg_dir,
  input  logic              cfg_stop_eq,
  input  logic [AW-1:0]     cfg_src,
  input  logic [AW-1:0]     cfg_dst,
  input  logic [CW-1:0]     cfg_cnt,
  input  logic [DATA_W-1:0] cfg_acc,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [AW-1:0]     src_next,
  input  logic [AW-1:0]     dst_next,
  input  logic              cmp_equal,
  output logic [DATA_W-1:0] cmp_lhs,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        sz,
  output logic              dir,
  output logic [AW-1:0]     src,
  output logic [AW-1:0]     dst,
  output logic [CW-1:0]     cnt,
  output logic [DATA_W-1:0] acc,
  output logic              zf
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  st_e               st_q, st_d;
  op_e               op_q, op_d;
  logic [1:0]        sz_q, sz_d;
  logic              dir_q, dir_d;
  logic              stop_q, stop_d;
  logic [AW-1:0]     src_q, src_d;
  logic [AW-1:0]     dst_q, dst_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic [DATA_W-1:0] opnd_q, opnd_d;
  logic              zf_q, zf_d;
  logic              done_q, done_d;

  logic [DATA_W-1:0] mask;
  logic              use_src;
  logic              use_dst;
  logic              is_test;
  logic              early_stop;
  op_e               op_in;

  assign mask       = size_mask(sz_q);
  assign is_test    = (op_q == OP_SCAN) || (op_q == OP_CMP);
  assign use_src    = (op_q == OP_MOVE) || (op_q == OP_LOAD) || (op_q == OP_CMP);
  assign use_dst    = (op_q == OP_MOVE) || (op_q == OP_STORE) ||
                      (op_q == OP_SCAN) || (op_q == OP_CMP);
  assign early_stop = is_test && (zf_q == stop_q);
  assign op_in      = (cfg_op > 3'd4) ? OP_MOVE : op_e'(cfg_op);

  // next-state process
  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    sz_d   = sz_q;
    dir_d  = dir_q;
    stop_d = stop_q;
    src_d  = src_q;
    dst_d  = dst_q;
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    opnd_d = opnd_q;
    zf_d   = zf_q;
    done_d = done_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          op_d   = op_in;
          sz_d   = cfg_size;
          dir_d  = cfg_dir;
          stop_d = cfg_stop_eq;
          src_d  = cfg_src;
          dst_d  = cfg_dst;
          cnt_d  = cfg_cnt;
          acc_d  = cfg_acc;
          zf_d   = 1'b0;
          if (cfg_cnt == '0) begin
            done_d = 1'b1;
          end else begin
            done_d = 1'b0;
            st_d   = first_state(op_in);
          end
        end
      end
      ST_RDA: begin
        if (mem_ack) begin
          opnd_d = mem_rdata & mask;
          case (op_q)
            OP_LOAD: begin
              acc_d = (acc_q & ~mask) | (mem_rdata & mask);
              st_d  = ST_STEP;
            end
            OP_CMP:  st_d = ST_RDB;
            default: st_d = ST_WR;
          endcase
        end
      end
      ST_RDB: begin
        if (mem_ack) begin
          zf_d = cmp_equal;
          st_d = ST_STEP;
        end
      end
      ST_WR: begin
        if (mem_ack) st_d = ST_STEP;
      end
      ST_STEP: begin
        if (use_src) src_d = src_next;
        if (use_dst) dst_d = dst_next;
        cnt_d = cnt_q - CNT_ONE;
        if ((cnt_q == CNT_ONE) || early_stop) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          st_d = first_state(op_q);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_MOVE;
      sz_q   <= 2'd0;
      dir_q  <= 1'b0;
      stop_q <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      acc_q  <= '0;
      opnd_q <= '0;
      zf_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      sz_q   <= sz_d;
      dir_q  <= dir_d;
      stop_q <= stop_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      opnd_q <= opnd_d;
      zf_q   <= zf_d;
      done_q <= done_d;
    end
  end

  // memory port decode
  always_comb begin
    mem_req  = (st_q == ST_RDA) || (st_q == ST_RDB) || (st_q == ST_WR);
    mem_we   = (st_q == ST_WR);
    mem_addr = (st_q == ST_RDA) ? src_q : dst_q;
    if (op_q == OP_STORE) mem_wdata = acc_q & mask;
    else                  mem_wdata = opnd_q;
  end

  assign cmp_lhs = (op_q == OP_SCAN) ? acc_q : opnd_q;
  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign sz      = sz_q;
  assign dir     = dir_q;
  assign src     = src_q;
  assign dst     = dst_q;
  assign cnt     = cnt_q;
  assign acc     = acc_q;
  assign zf      = zf_q;
endmodule

// File: rtl/rep_string_engine.sv
module rep_string_engine
  import rse_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    cfg_op,
  input  logic [1:0]    cfg_size,
  input  logic          cfg_dir,
  input  logic          cfg_stop_eq,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_cnt,
  input  logic [31:0]   cfg_acc,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] res_src,
  output logic [AW-1:0] res_dst,
  output logic [CW-1:0] res_cnt,
  output logic [31:0]   res_acc,
  output logic          res_zf
);
  logic [AW-1:0]     src_next;
  logic [AW-1:0]     dst_next;
  logic [DATA_W-1:0] cmp_lhs;
  logic              cmp_equal;
  logic              step_dir;

  rse_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cfg_op     (cfg_op),
    .cfg_size   (cfg_size),
    .cfg_dir    (cfg_dir),
    .cfg_stop_eq(cfg_stop_eq),
    .cfg_src    (cfg_src),
    .cfg_dst    (cfg_dst),
    .cfg_cnt    (cfg_cnt),
    .cfg_acc    (cfg_acc),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .src_next   (src_next),
    .dst_next   (dst_next),
    .cmp_equal  (cmp_equal),
    .cmp_lhs    (cmp_lhs),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .busy       (busy),
    .done       (done),
    .sz         (mem_size),
    .dir        (step_dir),
    .src        (res_src),
    .dst        (res_dst),
    .cnt        (res_cnt),
    .acc        (res_acc),
    .zf         (res_zf)
  );

  rse_stepper #(.AW(AW)) u_step_src (
    .ptr     (res_src),
    .sz      (mem_size),
    .dir     (step_dir),
    .ptr_next(src_next)
  );

  rse_stepper #(.AW(AW)) u_step_dst (
    .ptr     (res_dst),
    .sz      (mem_size),
    .dir     (step_dir),
    .ptr_next(dst_next)
  );

  rse_match u_match (
    .lhs  (cmp_lhs),
    .rhs  (mem_rdata),
    .sz   (mem_size),
    .equal(cmp_equal)
  );
endmodule

// File: rtl/rse_checker.sv
module rse_checker #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [CW-1:0] cfg_cnt,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] res_cnt
);
  // R2: an empty run finishes at once
  p_zero_count_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (cfg_cnt == '0)) |=> (done && !busy));

  // R11: request held steady until acknowledged
  p_req_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  // R13: idle engine issues no memory traffic
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // R13: done and busy are exclusive
  p_done_excl_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  // R5 / R12: the count never grows during a run
  p_cnt_never_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (res_cnt <= $past(res_cnt)));

  // R1: reset state
  always_comb begin
    if (!rst_n) begin
      a_reset_idle_r1: assert (!busy || !done);
    end
  end
endmodule

bind rep_string_engine rse_checker #(.AW(AW), .CW(CW)) u_rse_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .cfg_cnt  (cfg_cnt),
  .mem_req  (mem_req),
  .mem_ack  (mem_ack),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .busy     (busy),
  .done     (done),
  .res_cnt  (res_cnt)
);

// File: tb/test_rep_string_engine.sv
module test_rep_string_engine;
  localparam int AW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [2:0]    cfg_op;
  logic [1:0]    cfg_size;
  logic          cfg_dir;
  logic          cfg_stop_eq;
  logic [AW-1:0] cfg_src, cfg_dst;
  logic [CW-1:0] cfg_cnt;
  logic [31:0]   cfg_acc;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_size;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          busy, done, res_zf;
  logic [AW-1:0] res_src, res_dst;
  logic [CW-1:0] res_cnt;
  logic [31:0]   res_acc;

  always #10 clk = ~clk;

  rep_string_engine #(.AW(AW), .CW(CW)) i_rep_string_engine (.*);

  logic [7:0] mem [256];
  logic [7:0] emem [256];
  int checks = 0;
  int fails  = 0;
  int acks   = 0;

  // expected results
  logic [AW-1:0] e_src, e_dst;
  logic [CW-1:0] e_cnt;
  logic [31:0]   e_acc;
  logic          e_zf;
  int            e_acks;

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // memory responder: acknowledges after a random wait, one-cycle ack
  initial begin
    mem_ack   = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req && ($urandom % 3 != 0)) begin
        int nb;
        nb = (mem_size == 2'd0) ? 1 : (mem_size == 2'd1) ? 2 : 4;
        if (mem_we) begin
          for (int i = 0; i < nb; i++) mem[8'(mem_addr + AW'(i))] = mem_wdata[8*i +: 8];
        end else begin
          mem_rdata = $urandom;
          for (int i = 0; i < nb; i++) mem_rdata[8*i +: 8] = mem[8'(mem_addr + AW'(i))];
        end
        acks++;
        mem_ack = 1'b1;
      end
    end
  end

  function automatic logic [31:0] mask_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] rd_e(input logic [AW-1:0] a, input int nb);
    logic [31:0] v = '0;
    for (int i = 0; i < nb; i++) v[8*i +: 8] = emem[8'(a + AW'(i))];
    return v;
  endfunction

  // software model of one run
  task automatic model(input logic [2:0] op, input logic [1:0] sz, input logic dir,
                       input logic stp, input logic [AW-1:0] s, input logic [AW-1:0] d,
                       input logic [CW-1:0] n, input logic [31:0] acc);
    int nb;
    logic [31:0] m, a, b;
    logic [2:0] k;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    m  = mask_of(sz);
    k  = (op > 3'd4) ? 3'd0 : op;
    e_src = s; e_dst = d; e_cnt = n; e_acc = acc; e_zf = 1'b0; e_acks = 0;
    while (e_cnt != 0) begin
      case (k)
        3'd0: begin
          a = rd_e(e_src, nb);
          for (int i = 0; i < nb; i++) emem[8'(e_dst + AW'(i))] = a[8*i +: 8];
          e_acks += 2;
        end
        3'd1: begin
          for (int i = 0; i < nb; i++) emem[8'(e_dst + AW'(i))] = e_acc[8*i +: 8];
          e_acks += 1;
        end
        3'd2: begin
          e_acc = (e_acc & ~m) | rd_e(e_src, nb);
          e_acks += 1;
        end
        3'd3: begin
          e_zf = ((e_acc & m) == rd_e(e_dst, nb));
          e_acks += 1;
        end
        default: begin
          a = rd_e(e_src, nb);
          b = rd_e(e_dst, nb);
          e_zf = (a == b);
          e_acks += 2;
        end
      endcase
      if (k != 3'd1 && k != 3'd3) e_src = dir ? e_src - AW'(nb) : e_src + AW'(nb);
      if (k != 3'd2)              e_dst = dir ? e_dst - AW'(nb) : e_dst + AW'(nb);
      e_cnt = e_cnt - 1'b1;
      if ((k == 3'd3 || k == 3'd4) && (e_zf == stp)) break;
    end
  endtask

  string op_tag [5] = '{"R5", "R6", "R7", "R8", "R9"};

  // issue one run, optionally poking start mid-run, then check results
  task automatic run(input logic [2:0] op, input logic [1:0] sz, input logic dir,
                     input logic stp, input logic [AW-1:0] s, input logic [AW-1:0] d,
                     input logic [CW-1:0] n, input logic [31:0] acc, input bit poke);
    string tg;
    int wait_cyc;
    int bad;
    tg = op_tag[(op > 3'd4) ? 0 : op];
    foreach (mem[i]) emem[i] = mem[i];
    model(op, sz, dir, stp, s, d, n, acc);
    @(negedge clk);
    cfg_op = op; cfg_size = sz; cfg_dir = dir; cfg_stop_eq = stp;
    cfg_src = s; cfg_dst = d; cfg_cnt = n; cfg_acc = acc;
    acks  = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      check("R2", "done after one cycle", done, 1);
      check("R13", "busy with done", busy, 0);
    end
    wait_cyc = 0;
    while (!done && wait_cyc < 3000) begin
      if (poke && wait_cyc == 3 && busy) begin
        // R12: garbage start while busy must be ignored
        cfg_op = 3'd1; cfg_cnt = '0; cfg_src = '0; cfg_dst = '0; cfg_acc = '1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end else begin
        @(negedge clk);
      end
      wait_cyc++;
    end
    check(tg, "run completed", done, 1);
    check("R13", "busy low at done", busy, 0);
    check(poke ? "R12" : "R3 R4", "final source pointer", res_src, e_src);
    check(poke ? "R12" : "R3 R4", "final destination pointer", res_dst, e_dst);
    check((op == 3'd3 || op == 3'd4) ? "R10" : tg, "final count", res_cnt, e_cnt);
    check(tg, "accumulator", res_acc, e_acc);
    check("R10", "zero flag", res_zf, e_zf);
    check(n == 0 ? "R2" : tg, "memory access count", acks, e_acks);
    bad = 0;
    foreach (mem[i]) if (mem[i] !== emem[i]) bad++;
    check(tg, "bytes differing from model", bad, 0);
    @(negedge clk);
    check("R13", "done held while idle", done, 1);
  endtask

  initial begin
    int seed_ok;
    seed_ok = $urandom(32'd20240611);
    rst_n = 1'b0; start = 1'b0;
    cfg_op = '0; cfg_size = '0; cfg_dir = 1'b0; cfg_stop_eq = 1'b0;
    cfg_src = '0; cfg_dst = '0; cfg_cnt = '0; cfg_acc = '0;
    foreach (mem[i]) mem[i] = 8'($urandom % 4);
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", busy, 0);
    check("R1", "done in reset", done, 0);
    check("R1", "mem_req in reset", mem_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "busy after reset", busy, 0);
    check("R1", "mem_req after reset", mem_req, 0);

    // directed corner cases
    run(3'd0, 2'd0, 1'b0, 1'b0, 16'd40, 16'd90, 16'd0, 32'h1234_5678, 1'b0); // R2
    run(3'd0, 2'd0, 1'b0, 1'b0, 16'd16, 16'd120, 16'd9, 32'h0, 1'b0);        // R5 R3
    run(3'd0, 2'd2, 1'b1, 1'b0, 16'd100, 16'd200, 16'd6, 32'h0, 1'b0);       // R4
    run(3'd1, 2'd1, 1'b0, 1'b0, 16'd60, 16'd130, 16'd7, 32'hA5C3_5AB7, 1'b0);// R6
    run(3'd2, 2'd1, 1'b1, 1'b0, 16'd90, 16'd10, 16'd3, 32'hDEAD_BEEF, 1'b0); // R7
    run(3'd1, 2'd3, 1'b0, 1'b0, 16'd4, 16'd64, 16'd2, 32'h0102_0304, 1'b0);  // R3 code 3
    // R8 / R10: planted match at element 3
    for (int i = 0; i < 16; i++) mem[8'(70 + i)] = 8'h11;
    mem[76] = 8'h7E; mem[77] = 8'h5A;
    run(3'd3, 2'd1, 1'b0, 1'b1, 16'd0, 16'd70, 16'd8, 32'hFFFF_5A7E, 1'b0);
    // R9 / R10: identical regions except element 2, stop on mismatch
    for (int i = 0; i < 12; i++) begin mem[8'(140 + i)] = 8'(i); mem[8'(180 + i)] = 8'(i); end
    mem[188] = 8'hEE;
    run(3'd4, 2'd2, 1'b0, 1'b0, 16'd140, 16'd180, 16'd3, 32'h0, 1'b0);
    // R12: start pulse while busy
    run(3'd0, 2'd1, 1'b0, 1'b0, 16'd20, 16'd150, 16'd8, 32'h0, 1'b1);

    // constrained random runs
    for (int t = 0; t < 60; t++) begin
      logic [2:0] op;
      logic [1:0] sz;
      op = 3'($urandom % 6);
      sz = 2'($urandom % 4);
      foreach (mem[i]) mem[i] = 8'($urandom % 3);
      run(op, sz, 1'($urandom % 2), 1'($urandom % 2),
          AW'(64 + $urandom % 128), AW'(64 + $urandom % 128),
          CW'($urandom % 17), $urandom, 1'($urandom % 4 == 0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule